// File: doc/BRIEF.md
# Four-Channel Timer Input Capture

This block timestamps activity on four external pins against a free-running counter that another block supplies. Each channel resynchronises its pin into the local clock domain and detects rising and falling transitions. When a transition of an enabled kind appears, the channel copies the counter value into its own capture register. Each channel can also mark the event as pending. The block raises a single interrupt line while any channel has a pending event.

Software programs the block through a single-cycle register port with a write strobe, a word address and write data. Read data is combinational from the address. The control word holds one 3-bit field per channel. The status word holds one pending bit per channel, and writing a 1 to a bit clears it. The capture registers are read-only.

Register map (word addresses): 0 is control, 1 is status, and 2+n is the capture register of channel n. Any other address reads 0.

Top module: `input_capture_unit`

## Requirements
- R1: After reset, the control word, status word, all four capture registers and `irq_o` read 0.
- R2: Control field of channel n: bit 3n enables rising-edge capture, bit 3n+1 enables falling-edge capture, and bit 3n+2 enables the pending flag. Bits 11:0 read back as written. Bits 31:12 ignore writes and read 0.
- R3: A pin change from 0 to 1 on a channel with its rise enable set loads that channel's capture register with `cnt_i` as sampled at the clock edge two cycles after the edge that first samples the new pin level. The value is readable after that edge.
- R4: A pin change from 1 to 0 on a channel with its fall enable set loads the capture register in the same way as R3.
- R5: With both enables set, a channel captures on every change of its pin.
- R6: A transition whose enable bit is clear leaves every capture register unchanged, and so does any transition on another channel.
- R7: A capture on a channel with its flag enable set sets status bit n in the same edge as the load. A capture with the flag enable clear still loads the register but leaves the status bit at 0.
- R8: Writing the status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: If a flagged capture and a clear of the same status bit land on the same clock edge, the bit stays set.
- R10: `irq_o` is 1 exactly when at least one status bit is 1.
- R11: Writes to capture register addresses have no effect on the values read there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 4 | Capture pins, one per channel, asynchronous to clk |
| cnt_i | input | 32 | Free-running counter value |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
A pin change first reaches the capture register and the status bit at the third rising edge after the pin is driven. That edge takes `cnt_i` as held during the preceding cycle. The bench therefore steps the counter on every falling edge and expects the base value plus two. A control or status write takes effect at the edge after the strobe is raised. Read data and `irq_o` are sampled in the low phase that follows. The same-edge clear case is timed so the strobe coincides with that third edge, and the bench sweeps every channel, edge mode, flag enable and edge direction while tracking an arithmetic model of all four registers.

// File: rtl/icu_pkg.sv
package icu_pkg;

   localparam int unsigned FIELD_W   = 3;
   localparam int unsigned ADR_CTRL  = 0;
   localparam int unsigned ADR_STAT  = 1;
   localparam int unsigned ADR_CAP0  = 2;

   // one channel's control field; rise enable sits in the lowest bit
   typedef struct packed {
      logic flag_en;
      logic fall_en;
      logic rise_en;
   } chan_ctrl_t;

endpackage

// File: rtl/icu_edge_detect.sv
module icu_edge_detect #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   logic level;
   logic level_d;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign level = pin_i;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q[0] <= pin_i;
               for (int i = 1; i < int'(SYNC_STAGES); i++) begin
                  sync_q[i] <= sync_q[i-1];
               end
            end
         end
         assign level = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_d <= 1'b0;
      end else begin
         level_d <= level;
      end
   end

   assign rise_o = level & ~level_d;
   assign fall_o = ~level & level_d;

endmodule

// File: rtl/icu_channel.sv
module icu_channel
   import icu_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chan_ctrl_t       ctrl_i,
   input  logic             rise_i,
   input  logic             fall_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             clr_i,
   output logic             load_o,
   output logic             flag_o,
   output logic [CNT_W-1:0] cap_o
);

   logic [CNT_W-1:0] cap_q;
   logic             flag_q;

   assign load_o = (rise_i & ctrl_i.rise_en) | (fall_i & ctrl_i.fall_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
      end else if (load_o) begin
         cap_q <= cnt_i;
      end
   end

   // a new flagged event wins over a clear on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (load_o && ctrl_i.flag_en) begin
         flag_q <= 1'b1;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign cap_o  = cap_q;
   assign flag_o = flag_q;

endmodule

// File: rtl/icu_regs.sv
module icu_regs
   import icu_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [DATA_W-1:0]       wdata_i,
   input  logic [NUM_CH-1:0]       flag_i,
   input  logic [NUM_CH*CNT_W-1:0] cap_i,
   output logic [FIELD_W*NUM_CH-1:0] ctrl_o,
   output logic [NUM_CH-1:0]       clr_o,
   output logic [DATA_W-1:0]       rdata_o
);

   localparam int unsigned CTRL_W = FIELD_W * NUM_CH;

   generate
      if (CTRL_W > DATA_W) begin : g_bad_ctrl
         $error("control fields do not fit the data word");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("counter is wider than the data word");
      end
      if ((ADR_CAP0 + NUM_CH) > (2 ** ADDR_W)) begin : g_bad_addr
         $error("address width too small for the register map");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic              hit_ctrl;
   logic              hit_stat;
   logic              unused_wdata;

   assign hit_ctrl     = (addr_i == ADDR_W'(ADR_CTRL));
   assign hit_stat     = (addr_i == ADDR_W'(ADR_STAT));
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en_i && hit_ctrl) begin
         ctrl_q <= wdata_i[CTRL_W-1:0];
      end
   end

   assign clr_o  = (wr_en_i && hit_stat) ? wdata_i[NUM_CH-1:0] : '0;
   assign ctrl_o = ctrl_q;

   always_comb begin
      rdata_o = '0;
      if (hit_ctrl) begin
         rdata_o = DATA_W'(ctrl_q);
      end else if (hit_stat) begin
         rdata_o = DATA_W'(flag_i);
      end else begin
         for (int n = 0; n < int'(NUM_CH); n++) begin
            if (addr_i == ADDR_W'(ADR_CAP0 + n)) begin
               rdata_o = DATA_W'(cap_i[n*CNT_W +: CNT_W]);
            end
         end
      end
   end

endmodule

// File: rtl/input_capture_unit.sv
module input_capture_unit
   import icu_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] cap_pin_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);

   localparam int unsigned CTRL_W = FIELD_W * NUM_CH;

   generate
      if (NUM_CH == 0) begin : g_bad_nch
         $error("at least one channel is required");
      end
   endgenerate

   logic [CTRL_W-1:0]       ctrl_v;
   logic [NUM_CH-1:0]       clr_v;
   logic [NUM_CH-1:0]       flag_v;
   logic [NUM_CH-1:0]       load_v;
   logic [NUM_CH-1:0]       rise_v;
   logic [NUM_CH-1:0]       fall_v;
   logic [NUM_CH*CNT_W-1:0] cap_flat;

   icu_regs #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .flag_i  (flag_v),
      .cap_i   (cap_flat),
      .ctrl_o  (ctrl_v),
      .clr_o   (clr_v),
      .rdata_o (rdata_o)
   );

   generate
      for (genvar n = 0; n < int'(NUM_CH); n++) begin : g_ch
         icu_edge_detect #(
            .SYNC_STAGES (SYNC_STAGES)
         ) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (cap_pin_i[n]),
            .rise_o (rise_v[n]),
            .fall_o (fall_v[n])
         );

         icu_channel #(
            .CNT_W (CNT_W)
         ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl_i (chan_ctrl_t'(ctrl_v[n*FIELD_W +: FIELD_W])),
            .rise_i (rise_v[n]),
            .fall_i (fall_v[n]),
            .cnt_i  (cnt_i),
            .clr_i  (clr_v[n]),
            .load_o (load_v[n]),
            .flag_o (flag_v[n]),
            .cap_o  (cap_flat[n*CNT_W +: CNT_W])
         );
      end
   endgenerate

   assign irq_o = |flag_v;

endmodule

// File: rtl/icu_checker.sv
module icu_checker #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en_i,
   input logic [ADDR_W-1:0]       addr_i,
   input logic [DATA_W-1:0]       rdata_o,
   input logic [CNT_W-1:0]        cnt_i,
   input logic                    irq_o,
   input logic [3*NUM_CH-1:0]     ctrl_v,
   input logic [NUM_CH-1:0]       clr_v,
   input logic [NUM_CH-1:0]       load_v,
   input logic [NUM_CH-1:0]       flag_v,
   input logic [NUM_CH*CNT_W-1:0] cap_flat
);

   // reserved control bits always read as zero
   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == '0) |-> ((rdata_o >> (3*NUM_CH)) == '0));

   // interrupt only drops after a status write
   p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(wr_en_i && (addr_i == ADDR_W'(1))));

   generate
      for (genvar n = 0; n < int'(NUM_CH); n++) begin : g_chk
         p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
            load_v[n] |=> (cap_flat[n*CNT_W +: CNT_W] == $past(cnt_i)));

         p_no_load_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !load_v[n] |=> $stable(cap_flat[n*CNT_W +: CNT_W]));

         p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (load_v[n] && ctrl_v[3*n+2]) |=> flag_v[n]);

         p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_v[n] && !clr_v[n]) |=> flag_v[n]);

         p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[n] && !(load_v[n] && ctrl_v[3*n+2])) |=> !flag_v[n]);

         p_clear_race_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[n] && load_v[n] && ctrl_v[3*n+2]) |=> flag_v[n]);
      end
   endgenerate

endmodule

bind input_capture_unit icu_checker #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_icu_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en_i  (wr_en_i),
   .addr_i   (addr_i),
   .rdata_o  (rdata_o),
   .cnt_i    (cnt_i),
   .irq_o    (irq_o),
   .ctrl_v   (ctrl_v),
   .clr_v    (clr_v),
   .load_v   (load_v),
   .flag_v   (flag_v),
   .cap_flat (cap_flat)
);

// File: tb/input_capture_unit_tb.sv
module input_capture_unit_tb;

   localparam int NCH = 4;

   logic           clk = 1'b0;
   logic           rst_n;
   logic [NCH-1:0] cap_pin_i;
   logic [31:0]    cnt_i;
   logic           wr_en_i;
   logic [3:0]     addr_i;
   logic [31:0]    wdata_i;
   logic [31:0]    rdata_o;
   logic           irq_o;

   int checks = 0;
   int errors = 0;
   logic [31:0]    exp_cap [NCH];
   logic [NCH-1:0] exp_flag;

   always #4 clk = ~clk;

   input_capture_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_pin_i (cap_pin_i),
      .cnt_i     (cnt_i),
      .wr_en_i   (wr_en_i),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .rdata_o   (rdata_o),
      .irq_o     (irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      addr_i = a;
      #1;
      d = rdata_o;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en_i = 1'b1;
      addr_i  = a;
      wdata_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   // drive a pin level and step the counter; the load happens on the third edge,
   // taking base+2. Optionally a status clear is timed onto that same edge.
   task automatic drive_edge(input int n, input logic val, input logic [31:0] base,
                             input bit clr_same);
      @(negedge clk);
      cap_pin_i[n] = val;
      cnt_i = base;
      @(negedge clk);
      cnt_i = base + 32'd1;
      @(negedge clk);
      cnt_i = base + 32'd2;
      if (clr_same) begin
         wr_en_i = 1'b1;
         addr_i  = 4'd1;
         wdata_i = 32'd1 << n;
      end
      @(negedge clk);
      wr_en_i = 1'b0;
      cnt_i = base + 32'd3;
   endtask

   task automatic check_all(input string req);
      logic [31:0] d;
      for (int n = 0; n < NCH; n++) begin
         rd(4'(2 + n), d);
         chk(req, d, exp_cap[n], $sformatf("capture ch%0d", n));
      end
      rd(4'd1, d);
      chk(req, d, {28'd0, exp_flag}, "status");
      chk("R10", {31'd0, irq_o}, {31'd0, |exp_flag}, "irq");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] base;
      int ev;
      rst_n = 1'b0;
      cap_pin_i = '0;
      cnt_i = '0;
      wr_en_i = 1'b0;
      addr_i = '0;
      wdata_i = '0;
      for (int n = 0; n < NCH; n++) exp_cap[n] = '0;
      exp_flag = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'd0, d);
      chk("R1", d, 32'd0, "control");
      check_all("R1");

      // R2 field layout and reserved bits
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, d);
      chk("R2", d, 32'h0000_0FFF, "control all ones");
      wr(4'd0, 32'h1234_50A5);
      rd(4'd0, d);
      chk("R2", d, 32'h0000_00A5, "control pattern");
      wr(4'd0, 32'd0);

      // R3 R4 R5 R6 R7 sweep: channel x edge mode x flag enable x direction
      ev = 0;
      for (int n = 0; n < NCH; n++) begin
         for (int mode = 1; mode <= 3; mode++) begin
            for (int ie = 0; ie <= 1; ie++) begin
               wr(4'd0, 32'((mode | (ie << 2))) << (3 * n));
               for (int dir = 1; dir >= 0; dir--) begin
                  bit hit;
                  base = 32'h1357_0000 + 32'(ev * 37) + (32'(n) << 24);
                  ev++;
                  hit = (dir == 1) ? mode[0] : mode[1];
                  drive_edge(n, dir[0], base, 1'b0);
                  if (hit) exp_cap[n] = base + 32'd2;
                  if (hit && ie == 1) exp_flag[n] = 1'b1;
                  check_all(dir == 1 ? (mode == 2 ? "R6" : "R3")
                                     : (mode == 1 ? "R6" : (mode == 3 ? "R5" : "R4")));
               end
               wr(4'd1, 32'h0000_000F);
               exp_flag = '0;
               check_all("R7");
            end
         end
      end

      // R9 clear and flagged capture on the same edge; R8 write-one-to-clear
      wr(4'd0, 32'h0000_0005);
      drive_edge(0, 1'b1, 32'hA000_0000, 1'b0);
      exp_cap[0] = 32'hA000_0002;
      exp_flag[0] = 1'b1;
      check_all("R3");
      drive_edge(0, 1'b0, 32'hB000_0000, 1'b0);
      check_all("R6");
      drive_edge(0, 1'b1, 32'hC000_0000, 1'b1);
      exp_cap[0] = 32'hC000_0002;
      check_all("R9");
      wr(4'd1, 32'h0000_000E);
      check_all("R8");
      wr(4'd1, 32'h0000_0001);
      exp_flag[0] = 1'b0;
      check_all("R8");
      drive_edge(0, 1'b0, 32'hC100_0000, 1'b0);

      // R10 two pending flags
      wr(4'd0, 32'h0000_0145);
      drive_edge(0, 1'b1, 32'hD000_0000, 1'b0);
      drive_edge(2, 1'b1, 32'hE000_0000, 1'b0);
      exp_cap[0] = 32'hD000_0002;
      exp_cap[2] = 32'hE000_0002;
      exp_flag = 4'b0101;
      check_all("R10");
      wr(4'd1, 32'h0000_0001);
      exp_flag = 4'b0100;
      check_all("R10");
      wr(4'd1, 32'h0000_0004);
      exp_flag = 4'b0000;
      check_all("R10");

      // R11 capture registers ignore writes
      for (int n = 0; n < NCH; n++) begin
         wr(4'(2 + n), 32'hDEAD_BEEF);
      end
      check_all("R11");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule